// File: doc/BRIEF.md
# Stack Machine Chained-Micro-Operation ALU Stage

This block executes one arithmetic/logic instruction of a 16-bit stack processor. The instruction carries a 12-bit parameter field. Each bit or small group of bits in that field enables one simple step. The steps always run in a fixed order, from the least significant field to the most significant. Because of this, setting several fields at once builds compound operations: negation, subtraction, decrement, shifts and an indirect subroutine call.

The surrounding core supplies four values at issue:
- the top two stack words;
- the carry bit, which acts as a 17th bit above the top word;
- the address of the following instruction.

One cycle later the block returns the new top word and the new carry. It also flags whether the second word was consumed. When the instruction asks for it, the block raises a request to push the return address onto the call stack, a request to jump, or both. The core owns memory, the stack pointers and instruction fetch.

Top module: `stack_alu_exec`

## Requirements
- R1: Results appear on the outputs on the clock edge after `issueValid` is sampled high, with `resultValid` high for exactly that one cycle. While reset is active, and in any cycle without a result, `resultValid`, `pushReq` and `jumpReq` are low.
- R2: Field bit 0 complements the top word and bit 1 then increments it (modulo 2^16). Neither step ever changes the carry.
- R3: Bit 3 clears the carry and bit 4 then complements it. If bit 2 is set and the top word, after the R2 steps, has its MSB clear, both carry steps are skipped.
- R4: Bit 5 selects operand B: 0 selects the second stack word, 1 selects the constant 0xFFFF. `nosConsumed` is high exactly when the second word was selected.
- R5: Bits 7:6 select the binary step: 00 add, 01 AND, 10 OR, 11 XOR. Add writes its carry-out into the carry bit. AND, OR and XOR keep the carry.
- R6: Bits 9:8 select the shift step. 00 does nothing. 01 rotates the 17-bit value {carry, top} right by one. 10 rotates it left by one.
- R7: Bits 9:8 = 11 swap the two bytes of the top word and leave the carry as the earlier steps left it.
- R8: Bit 10 raises `pushReq` with `pushAddr` equal to the supplied next-instruction address.
- R9: Bit 11 raises `jumpReq` with `jumpTarget` equal to the final top word after all earlier steps.
- R10: The chained fields give these compound results:
  - negate: bits 0,1 with AND and constant operand;
  - subtract: bits 0,1 with add of the second word gives NOS−TOS, with carry meaning no borrow;
  - decrement: bits 0,1 and XOR with the constant;
  - arithmetic shift right: bits 2,3,4 and rotate right, valid when the incoming carry is 0 or the value is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is presented this cycle |
| opField | input | 12 | Parameter field of the instruction |
| tosIn | input | 16 | Top stack word |
| nosIn | input | 16 | Second stack word |
| carryIn | input | 1 | Current carry bit |
| nextPc | input | 16 | Address of the following instruction |
| resultValid | output | 1 | Results below are valid this cycle |
| tosOut | output | 16 | New top stack word |
| carryOut | output | 1 | New carry bit |
| nosConsumed | output | 1 | Second word was used and removed |
| pushReq | output | 1 | Push return address onto call stack |
| pushAddr | output | 16 | Return address to push |
| jumpReq | output | 1 | Load instruction pointer |
| jumpTarget | output | 16 | Jump destination |

## Verification
The save-return-address request and the jump request can fall in the same result cycle. This is the indirect subroutine call, and the jump target must be the top word after every arithmetic step while the pushed address stays the next-instruction address. A directed case sets both bits together with a complement so that the two values differ. The full sweep over all 4096 field values also sets both bits in a quarter of its cases. Both requests and both addresses are compared against an arithmetic model in the same cycle.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 12;

  typedef enum logic [1:0] {
    BIN_ADD = 2'b00,
    BIN_AND = 2'b01,
    BIN_OR  = 2'b10,
    BIN_XOR = 2'b11
  } binOp_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_ROR  = 2'b01,
    SH_ROL  = 2'b10,
    SH_SWAP = 2'b11
  } shiftOp_e;

  typedef struct packed {
    logic     doCmp;
    logic     doInc;
    logic     keepIfPos;
    logic     doClrC;
    logic     doCmpC;
    logic     useOnes;
    binOp_e   binOp;
    shiftOp_e shiftOp;
    logic     doSave;
    logic     doJump;
  } aluStrobe_t;
endpackage

// File: rtl/stack_alu_ctrl.sv
module stack_alu_ctrl
  import stack_alu_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] opField,
  output aluStrobe_t     strobe
);
  // Field positions follow the execution order, low bit first.
  always_comb begin
    strobe.doCmp     = opField[0];
    strobe.doInc     = opField[1];
    strobe.keepIfPos = opField[2];
    strobe.doClrC    = opField[3];
    strobe.doCmpC    = opField[4];
    strobe.useOnes   = opField[5];
    strobe.binOp     = binOp_e'(opField[7:6]);
    strobe.shiftOp   = shiftOp_e'(opField[9:8]);
    strobe.doSave    = opField[10];
    strobe.doJump    = opField[11];
  end
endmodule

// File: rtl/stack_alu_dpath.sv
module stack_alu_dpath
  import stack_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         issueValid,
  input  aluStrobe_t   strobe,
  input  logic [W-1:0] tosIn,
  input  logic [W-1:0] nosIn,
  input  logic         carryIn,
  input  logic [W-1:0] nextPc,
  output logic         resultValid,
  output logic [W-1:0] tosOut,
  output logic         carryOut,
  output logic         nosConsumed,
  output logic         pushReq,
  output logic [W-1:0] pushAddr,
  output logic         jumpReq,
  output logic [W-1:0] jumpTarget
);
  localparam int HALF = W / 2;

  logic [W-1:0] preTos;
  logic [W-1:0] opB;
  logic [W-1:0] binTos;
  logic [W-1:0] finTos;
  logic [W:0]   sumWide;
  logic         preC;
  logic         binC;
  logic         finC;
  logic         skipCarry;

  // unary steps on the top word and the carry
  always_comb begin
    preTos = tosIn;
    if (strobe.doCmp) preTos = ~preTos;
    if (strobe.doInc) preTos = preTos + 1'b1;
    skipCarry = strobe.keepIfPos && !preTos[W-1];
    preC = carryIn;
    if (strobe.doClrC && !skipCarry) preC = 1'b0;
    if (strobe.doCmpC && !skipCarry) preC = ~preC;
  end

  // binary step
  always_comb begin
    opB     = strobe.useOnes ? {W{1'b1}} : nosIn;
    sumWide = {1'b0, preTos} + {1'b0, opB};
    binC    = preC;
    binTos  = preTos;
    unique case (strobe.binOp)
      BIN_ADD: begin binTos = sumWide[W-1:0]; binC = sumWide[W]; end
      BIN_AND: binTos = preTos & opB;
      BIN_OR:  binTos = preTos | opB;
      BIN_XOR: binTos = preTos ^ opB;
    endcase
  end

  // shift step through the carry
  always_comb begin
    finTos = binTos;
    finC   = binC;
    unique case (strobe.shiftOp)
      SH_NONE: ;
      SH_ROR: begin finTos = {binC, binTos[W-1:1]}; finC = binTos[0]; end
      SH_ROL: begin finTos = {binTos[W-2:0], binC}; finC = binTos[W-1]; end
      SH_SWAP: finTos = {binTos[HALF-1:0], binTos[W-1:HALF]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      tosOut      <= '0;
      carryOut    <= 1'b0;
      nosConsumed <= 1'b0;
      pushReq     <= 1'b0;
      pushAddr    <= '0;
      jumpReq     <= 1'b0;
      jumpTarget  <= '0;
    end else begin
      resultValid <= issueValid;
      nosConsumed <= issueValid && !strobe.useOnes;
      pushReq     <= issueValid && strobe.doSave;
      jumpReq     <= issueValid && strobe.doJump;
      if (issueValid) begin
        tosOut     <= finTos;
        carryOut   <= finC;
        pushAddr   <= nextPc;
        jumpTarget <= finTos;
      end
    end
  end
endmodule

// File: rtl/stack_alu_exec.sv
module stack_alu_exec
  import stack_alu_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           issueValid,
  input  logic [OPW-1:0] opField,
  input  logic [W-1:0]   tosIn,
  input  logic [W-1:0]   nosIn,
  input  logic           carryIn,
  input  logic [W-1:0]   nextPc,
  output logic           resultValid,
  output logic [W-1:0]   tosOut,
  output logic           carryOut,
  output logic           nosConsumed,
  output logic           pushReq,
  output logic [W-1:0]   pushAddr,
  output logic           jumpReq,
  output logic [W-1:0]   jumpTarget
);
  aluStrobe_t strobe;

  stack_alu_ctrl #(.OPW(OPW)) u_ctrl (
    .opField (opField),
    .strobe  (strobe)
  );

  stack_alu_dpath #(.W(W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .strobe      (strobe),
    .tosIn       (tosIn),
    .nosIn       (nosIn),
    .carryIn     (carryIn),
    .nextPc      (nextPc),
    .resultValid (resultValid),
    .tosOut      (tosOut),
    .carryOut    (carryOut),
    .nosConsumed (nosConsumed),
    .pushReq     (pushReq),
    .pushAddr    (pushAddr),
    .jumpReq     (jumpReq),
    .jumpTarget  (jumpTarget)
  );
endmodule

// File: rtl/stack_alu_exec_chk.sv
module stack_alu_exec_chk #(
  parameter int W   = 16,
  parameter int OPW = 12
) (
  input logic           clk,
  input logic           rstN,
  input logic           issueValid,
  input logic [OPW-1:0] opField,
  input logic           carryIn,
  input logic [W-1:0]   nextPc,
  input logic           resultValid,
  input logic           carryOut,
  input logic           nosConsumed,
  input logic           pushReq,
  input logic [W-1:0]   pushAddr,
  input logic           jumpReq
);
  // R1
  result_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid == $past(issueValid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!pushReq && !jumpReq && !nosConsumed));

  // R4
  operand_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (nosConsumed == !$past(opField[5])));

  // R8
  push_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |-> (pushAddr == $past(nextPc)));

  // R9
  jump_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (jumpReq == $past(opField[11])));

  // R7
  swap_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && $past(opField[9:8] == 2'b11 && opField[4:3] == 2'b00
                          && opField[7:6] != 2'b00))
      |-> (carryOut == $past(carryIn)));
endmodule

bind stack_alu_exec stack_alu_exec_chk #(.W(W), .OPW(OPW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .opField     (opField),
  .carryIn     (carryIn),
  .nextPc      (nextPc),
  .resultValid (resultValid),
  .carryOut    (carryOut),
  .nosConsumed (nosConsumed),
  .pushReq     (pushReq),
  .pushAddr    (pushAddr),
  .jumpReq     (jumpReq)
);

// File: tb/stack_alu_exec_bench.sv
module stack_alu_exec_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [11:0] opField = '0;
  logic [15:0] tosIn = '0;
  logic [15:0] nosIn = '0;
  logic        carryIn = 1'b0;
  logic [15:0] nextPc = '0;
  logic        resultValid;
  logic [15:0] tosOut;
  logic        carryOut;
  logic        nosConsumed;
  logic        pushReq;
  logic [15:0] pushAddr;
  logic        jumpReq;
  logic [15:0] jumpTarget;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stack_alu_exec u_stack_alu_exec (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opField(opField),
    .tosIn(tosIn), .nosIn(nosIn), .carryIn(carryIn), .nextPc(nextPc),
    .resultValid(resultValid), .tosOut(tosOut), .carryOut(carryOut),
    .nosConsumed(nosConsumed), .pushReq(pushReq), .pushAddr(pushAddr),
    .jumpReq(jumpReq), .jumpTarget(jumpTarget)
  );

  // field bits
  localparam int B_CMP = 0, B_INC = 1, B_PCP = 2, B_CLC = 3, B_CMC = 4;
  localparam int B_ONES = 5, B_SAV = 10, B_JMP = 11;

  function automatic logic [11:0] mk(input bit cmp, input bit inc, input bit pcp,
                                     input bit clc, input bit cmc, input bit ones,
                                     input logic [1:0] bop, input logic [1:0] sh,
                                     input bit sav, input bit jmp);
    return {jmp, sav, sh, bop, ones, cmc, clc, pcp, inc, cmp};
  endfunction

  // arithmetic model built from the requirements
  function automatic logic [16:0] model(input logic [11:0] op, input logic [15:0] t,
                                        input logic [15:0] n, input logic c);
    int unsigned v;
    int unsigned b;
    logic [15:0] r;
    logic cy;
    v = t;
    cy = c;
    if (op[B_CMP]) v = 16'hFFFF - v;
    if (op[B_INC]) v = (v + 1) % 65536;
    if (!(op[B_PCP] && v < 32768)) begin
      if (op[B_CLC]) cy = 1'b0;
      if (op[B_CMC]) cy = !cy;
    end
    b = op[B_ONES] ? 65535 : n;
    r = 16'(v);
    case (op[7:6])
      2'b00: begin cy = (v + b) >= 65536; r = 16'((v + b) % 65536); end
      2'b01: r = 16'(v) & 16'(b);
      2'b10: r = 16'(v) | 16'(b);
      default: r = 16'(v) ^ 16'(b);
    endcase
    v = r;
    case (op[9:8])
      2'b01: begin r = 16'(v / 2 + (cy ? 32768 : 0)); cy = (v % 2) == 1; end
      2'b10: begin r = 16'((v * 2) % 65536 + (cy ? 1 : 0)); cy = v >= 32768; end
      2'b11: r = 16'((v % 256) * 256 + v / 256);
      default: ;
    endcase
    return {cy, r};
  endfunction

  task automatic report(input string req, input bit ok, input string detail);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic issue(input logic [11:0] op, input logic [15:0] t, input logic [15:0] n,
                       input logic c, input logic [15:0] pc);
    @(negedge clk);
    issueValid = 1'b1; opField = op; tosIn = t; nosIn = n; carryIn = c; nextPc = pc;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic checkFull(input string req, input logic [11:0] op, input logic [15:0] t,
                           input logic [15:0] n, input logic c, input logic [15:0] pc);
    logic [16:0] e;
    bit ok;
    e = model(op, t, n, c);
    issue(op, t, n, c, pc);
    ok = resultValid && tosOut == e[15:0] && carryOut == e[16]
      && nosConsumed == !op[B_ONES] && pushReq == op[B_SAV] && jumpReq == op[B_JMP]
      && (!op[B_SAV] || pushAddr == pc) && (!op[B_JMP] || jumpTarget == e[15:0]);
    report(req, ok, $sformatf("op=%03h tos=%04h nos=%04h c=%0d: got tos=%04h c=%0d v=%0d nc=%0d p=%0d/%04h j=%0d/%04h exp tos=%04h c=%0d",
           op, t, n, c, tosOut, carryOut, resultValid, nosConsumed, pushReq, pushAddr,
           jumpReq, jumpTarget, e[15:0], e[16]));
  endtask

  task automatic checkVal(input string req, input logic [15:0] gotT, input logic gotC,
                          input logic [15:0] expT, input logic expC);
    report(req, gotT == expT && gotC == expC,
           $sformatf("got %04h/%0d exp %04h/%0d", gotT, gotC, expT, expC));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [15:0] tv [4];
    logic [15:0] nv [4];
    repeat (3) @(negedge clk);
    // R1 reset state
    report("R1", !resultValid && !pushReq && !jumpReq,
           $sformatf("reset v=%0d p=%0d j=%0d exp 0", resultValid, pushReq, jumpReq));
    rstN = 1'b1;
    @(negedge clk);
    report("R1", !resultValid, $sformatf("idle v=%0d exp 0", resultValid));

    // R10 negate: 5 -> FFFB, carry kept
    issue(mk(1,1,0,0,0,1,2'b01,2'b00,0,0), 16'h0005, 16'h1234, 1'b1, 16'h0);
    checkVal("R10 neg", tosOut, carryOut, 16'hFFFB, 1'b1);
    // R10 subtract: 9 - 3 = 6, no borrow -> carry 1
    issue(mk(1,1,0,0,0,0,2'b00,2'b00,0,0), 16'h0003, 16'h0009, 1'b0, 16'h0);
    checkVal("R10 sub", tosOut, carryOut, 16'h0006, 1'b1);
    // R10 subtract with borrow: 3 - 9
    issue(mk(1,1,0,0,0,0,2'b00,2'b00,0,0), 16'h0009, 16'h0003, 1'b1, 16'h0);
    checkVal("R10 sub borrow", tosOut, carryOut, 16'hFFFA, 1'b0);
    // R10 decrement, carry untouched; 0 wraps to FFFF
    issue(mk(1,1,0,0,0,1,2'b11,2'b00,0,0), 16'h0000, 16'h0, 1'b1, 16'h0);
    checkVal("R10 dec", tosOut, carryOut, 16'hFFFF, 1'b1);
    // R10 arithmetic shift right, negative value
    issue(mk(0,0,1,1,1,1,2'b01,2'b01,0,0), 16'h8004, 16'h0, 1'b0, 16'h0);
    checkVal("R10 asr neg", tosOut, carryOut, 16'hC002, 1'b0);
    // R10 arithmetic shift right, positive value, carry in 0
    issue(mk(0,0,1,1,1,1,2'b01,2'b01,0,0), 16'h0007, 16'h0, 1'b0, 16'h0);
    checkVal("R10 asr pos", tosOut, carryOut, 16'h0003, 1'b1);
    // R3 skip: positive with pcp keeps carry 1 despite clc
    issue(mk(0,0,1,1,0,1,2'b01,2'b00,0,0), 16'h1000, 16'h0, 1'b1, 16'h0);
    checkVal("R3 skip", tosOut, carryOut, 16'h1000, 1'b1);
    // R7 swap keeps carry
    issue(mk(0,0,0,0,0,1,2'b01,2'b11,0,0), 16'hAB12, 16'h0, 1'b1, 16'h0);
    checkVal("R7 swap", tosOut, carryOut, 16'h12AB, 1'b1);
    // R6 rotate left through carry
    issue(mk(0,0,0,0,0,1,2'b01,2'b10,0,0), 16'h8001, 16'h0, 1'b1, 16'h0);
    checkVal("R6 rol", tosOut, carryOut, 16'h0003, 1'b1);
    // R5 add carry-out into carry
    issue(mk(0,0,0,0,0,0,2'b00,2'b00,0,0), 16'hFFFF, 16'h0002, 1'b0, 16'h0);
    checkVal("R5 add", tosOut, carryOut, 16'h0001, 1'b1);
    // R8 R9 push and jump in the same cycle
    issue(mk(1,0,0,0,0,1,2'b01,2'b00,1,1), 16'h0F00, 16'h0, 1'b0, 16'h4242);
    report("R8", pushReq && pushAddr == 16'h4242,
           $sformatf("push %0d/%04h exp 1/4242", pushReq, pushAddr));
    report("R9", jumpReq && jumpTarget == 16'hF0FF,
           $sformatf("jump %0d/%04h exp 1/f0ff", jumpReq, jumpTarget));
    @(negedge clk);
    report("R1", !resultValid && !pushReq && !jumpReq,
           $sformatf("after v=%0d p=%0d j=%0d exp 0", resultValid, pushReq, jumpReq));

    // exhaustive field sweep with several operand sets (R2 R3 R4 R5 R6 R9)
    tv[0] = 16'h0000; nv[0] = 16'h0000;
    tv[1] = 16'h8001; nv[1] = 16'h7FFF;
    tv[2] = 16'h7FFF; nv[2] = 16'h8001;
    tv[3] = 16'hA5C3; nv[3] = 16'h3C5A;
    for (int k = 0; k < 4; k++) begin
      for (int o = 0; o < 4096; o++) begin
        checkFull("R2/R3/R4/R5/R6/R8/R9 sweep", 12'(o), tv[k], nv[k], 1'((o + k) % 2),
                  16'(o * 2 + 2));
      end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule